// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block turns parallel words into an asynchronous serial bit stream with a start bit, optional parity and one or two stop bits. It has two storage stages. A single-word holding register takes a word on a load strobe. A shift register then drives the line one bit per bit period. Because of the holding register, the next word can be queued while the current frame is still going out, so a stream of words leaves with no gaps between frames.

Two status outputs support flow control. `hold_empty` shows that the holding register will accept a word. `tx_empty` shows that the holding register and the shift register are both idle. Word length, parity mode, stop bit count, clock frequency and bit rate are all fixed at compile time. The bit period in clock cycles is the clock frequency divided by the bit rate, rounded to the nearest integer.

Top module: `uart_tx_hold`

## Requirements
- R1: A `load` pulse while `hold_empty` is high stores `din` in the holding register, and `hold_empty` is low in the following cycle.
- R2: A `load` pulse while the holding register is full is ignored. The word already held is the one that is sent next.
- R3: If the shift register is idle and the holding register is full, the word moves to the shift register on the next clock edge. At that same edge `txd` goes low (start bit) and `hold_empty` goes high.
- R4: A frame is one low start bit, then the `WIDTH` data bits with the least significant bit first. Every bit lasts round(`CLK_HZ`/`BAUD`) clock cycles.
- R5: When `PARITY_EN`=1, one parity bit follows the data. With `PARITY_ODD`=0 the parity bit is chosen so that the data plus parity hold an even number of ones; with `PARITY_ODD`=1 the count is odd.
- R6: When `PARITY_EN`=0, no parity bit is sent and the stop bits come straight after the last data bit.
- R7: The frame ends with `STOP_BITS` (1 or 2) high stop bits.
- R8: If a word is waiting when the last stop bit ends, the next start bit begins in the very next cycle, with no idle time between frames.
- R9: `tx_empty` is high only when the shift register is idle and the holding register is empty.
- R10: `rst` is asynchronous. While it is high, `txd`, `hold_empty` and `tx_empty` are all high, even in the middle of a frame.
- R11: `txd` is high whenever no frame is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| load | input | 1 | Strobe that stores `din` in the holding register |
| din | input | WIDTH | Parallel word to send |
| txd | output | 1 | Serial line output, high when idle |
| hold_empty | output | 1 | Holding register can accept a word |
| tx_empty | output | 1 | Holding and shift register both idle |

## Verification
A wrong bit counter or divider shows up on the line within one frame, as a shifted sample or a misplaced stop or parity bit. A bad reload condition shows up at the next frame boundary, as an idle gap or a late start bit. A corrupted holding register or a missed ignore of `load` changes the data bits of the frame that follows. A wrong flag update appears at the `hold_empty` and `tx_empty` ports one clock after the load or the transfer that caused it.

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int WIDTH      = 8,
  parameter int CLK_HZ     = 50_000_000,
  parameter int BAUD       = 115_200,
  parameter int STOP_BITS  = 1,
  parameter bit PARITY_EN  = 1'b0,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic             txd,
  output logic             hold_empty,
  output logic             tx_empty
);
  localparam int DIV  = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int FLEN = 1 + WIDTH + (PARITY_EN ? 1 : 0) + STOP_BITS;
  localparam int BW   = $clog2(FLEN + 1);

  logic [WIDTH-1:0] hold_q;
  logic             hold_full;
  logic             busy;
  logic [FLEN-1:0]  sh;
  logic [FLEN-1:0]  frame;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bitn;

  wire tick = (cnt == CW'(DIV - 1));
  wire last = (bitn == BW'(FLEN - 1));
  wire take = hold_full && (!busy || (tick && last));

  always_comb begin
    frame = '1;
    frame[0] = 1'b0;
    frame[WIDTH:1] = hold_q;
    if (PARITY_EN) frame[WIDTH+1] = (^hold_q) ^ PARITY_ODD;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (take) begin
      hold_full <= 1'b0;
    end else if (load && !hold_full) begin
      hold_full <= 1'b1;
      hold_q    <= din;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      busy <= 1'b0;
      sh   <= '1;
      cnt  <= '0;
      bitn <= '0;
    end else if (take) begin
      busy <= 1'b1;
      sh   <= frame;
      cnt  <= '0;
      bitn <= '0;
    end else if (busy) begin
      if (tick) begin
        cnt  <= '0;
        sh   <= {1'b1, sh[FLEN-1:1]};
        bitn <= last ? '0 : bitn + 1'b1;
        if (last) busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign txd        = sh[0];
  assign hold_empty = !hold_full;
  assign tx_empty   = !busy && !hold_full;

  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    (load && hold_empty) |=> !hold_empty);
  a_r2_hold_kept: assert property (@(posedge clk) disable iff (rst)
    hold_full |=> (hold_q == $past(hold_q)));
  a_r3_start_bit: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !busy) |=> (busy && !txd && hold_empty));
  a_r4_bit_steady: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |-> $stable(txd));
  a_r8_no_gap: assert property (@(posedge clk) disable iff (rst)
    (busy && tick && last && hold_full) |=> (busy && !txd));
  a_r11_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
endmodule

// File: tb/sim_uart_tx_hold.sv
module sim_lane #(
  parameter int W    = 8,
  parameter bit PE   = 1'b1,
  parameter bit PO   = 1'b0,
  parameter int SB   = 1,
  parameter int BAUD = 12_500_000
) (
  input  logic clk,
  output logic done,
  output int   total,
  output int   bad
);
  localparam int DIV = (50_000_000 + BAUD / 2) / BAUD;
  localparam int FL  = 1 + W + (PE ? 1 : 0) + SB;
  localparam int N   = 1 << W;

  logic         rst, load;
  logic [W-1:0] din;
  logic         txd, he, te;

  uart_tx_hold #(.WIDTH(W), .CLK_HZ(50_000_000), .BAUD(BAUD), .STOP_BITS(SB),
                 .PARITY_EN(PE), .PARITY_ODD(PO)) u0 (
    .clk(clk), .rst(rst), .load(load), .din(din),
    .txd(txd), .hold_empty(he), .tx_empty(te));

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s (W=%0d) got=%0d exp=%0d t=%0t", req, W, got, exp, $time);
    end
  endtask

  function automatic int expbit(input logic [W-1:0] w, input int j);
    if (j == 0) return 0;
    if (j <= W) return int'(w[j-1]);
    if (PE && j == W + 1) return int'((^w) ^ PO);
    return 1;
  endfunction

  function automatic string tagof(input int j);
    if (j <= W) return "R4";
    if (PE && j == W + 1) return "R5";
    if (!PE && j == W + 1) return "R6";
    return "R7";
  endfunction

  initial begin
    total = 0; bad = 0; done = 0;
    rst = 1; load = 0; din = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset line", int'(txd), 1);
    chk("R10 reset hold_empty", int'(he), 1);
    chk("R10 reset tx_empty", int'(te), 1);
    rst = 0;
    @(negedge clk);
    chk("R11 idle line", int'(txd), 1);
    load = 1; din = '0;
    @(negedge clk);
    load = 0;
    chk("R1 hold full", int'(he), 0);
    chk("R9 tx_empty low", int'(te), 0);
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      for (int p = 0; p < FL * DIV; p++) begin
        if (p == 0) begin
          chk(k == 0 ? "R3 start bit" : "R8 back-to-back start", int'(txd), 0);
          chk("R3 hold_empty after transfer", int'(he), 1);
          if (k + 1 < N) begin load = 1; din = W'(k + 1); end
        end
        if (p == 1 && k + 1 < N) begin
          load = 0;
          chk("R1 hold full", int'(he), 0);
          chk("R9 tx_empty low", int'(te), 0);
        end
        if (p == 3 && k + 1 < N) begin load = 1; din = ~W'(k + 1); end
        if (p == 4) load = 0;
        if (p % DIV == DIV / 2) chk(tagof(p / DIV), int'(txd), expbit(W'(k), p / DIV));
        if (p == FL * DIV - 1 && k + 1 == N) chk("R9 busy on last stop", int'(te), 0);
        @(negedge clk);
      end
    end
    chk("R11 idle after stream", int'(txd), 1);
    chk("R9 tx_empty idle", int'(te), 1);
    chk("R1 hold_empty idle", int'(he), 1);
    repeat (2 * DIV) @(negedge clk);
    chk("R11 line stays high", int'(txd), 1);
    load = 1; din = '0;
    @(negedge clk);
    load = 0;
    @(negedge clk);
    load = 1; din = W'(5);
    @(negedge clk);
    load = 0;
    repeat (DIV + 1) @(negedge clk);
    chk("R4 data low before reset", int'(txd), 0);
    #3 rst = 1;
    #1;
    chk("R10 async line", int'(txd), 1);
    chk("R10 async hold_empty", int'(he), 1);
    chk("R10 async tx_empty", int'(te), 1);
    @(negedge clk);
    rst = 0;
    done = 1;
  end
endmodule

module sim_uart_tx_hold;
  logic clk = 0;
  always #10 clk = ~clk;

  logic d0, d1, d2;
  int   t0, t1, t2, b0, b1, b2;

  sim_lane #(.W(8), .PE(1'b1), .PO(1'b0), .SB(1), .BAUD(12_500_000))
    l0 (.clk(clk), .done(d0), .total(t0), .bad(b0));
  sim_lane #(.W(5), .PE(1'b1), .PO(1'b1), .SB(2), .BAUD(16_666_667))
    l1 (.clk(clk), .done(d1), .total(t1), .bad(b1));
  sim_lane #(.W(6), .PE(1'b0), .PO(1'b0), .SB(1), .BAUD(10_000_000))
    l2 (.clk(clk), .done(d2), .total(t2), .bad(b2));

  initial begin
    int cyc;
    int wd;
    cyc = 0;
    wd = 0;
    while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && cyc < 150_000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 150_000) begin
      wd = 1;
      $display("FAIL watchdog expired got=%0d exp=done", cyc);
    end
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", t0 + t1 + t2 + wd, b0 + b1 + b2 + wd);
    $finish;
  end
endmodule